// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel

This block timestamps transitions of one external input. The input is brought into the clock domain by a synchroniser. It is then gated by a connect enable and passed through an optional inverter. Each rising transition of the conditioned level copies the value of a free-running counter, supplied on `cnt_i`, into a rising-edge capture register. Each falling transition copies it into a separate falling-edge capture register. Software can later read both registers and work out pulse widths and periods from the two timestamps.

Each edge kind has its own "captured" flag, and software clears that flag by writing a zero to it. A combined interrupt flag is set when a captured edge has its interrupt enabled. That flag is cleared by writing a one, and it drives the interrupt output directly. The block does not contain the counter, the bus decoding or the pin multiplexing. Configuration arrives on level inputs, and flag writes arrive on a one-cycle write strobe with a 3-bit data word.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read 0, both edge flags are 0, and `irq_o` is 0.
- R2: A rising transition of the conditioned level loads `rise_cap_o` with the `cnt_i` value present at the third rising clock edge, counting from the edge that first samples the new pin level. The same clock edge sets `rise_flag_o`.
- R3: A falling transition of the conditioned level loads `fall_cap_o` and sets `fall_flag_o`, with the same timing as R2.
- R4: The conditioned level is (synchronised pin AND `connect_i`) XOR `invert_i`. With `invert_i` high, a pin going high is therefore captured as a falling edge.
- R5: While `connect_i` is 0, pin activity does not change the capture registers or the flags.
- R6: While `cap_en_i` is 0, an edge loads no register, sets no flag and raises no interrupt.
- R7: A write (`flag_wr_i` high) with `flag_wdata_i[0]`=0 clears `rise_flag_o`, and a write with `flag_wdata_i[1]`=0 clears `fall_flag_o`. A 1 in either bit leaves that flag unchanged. A capture in the same cycle wins over the clear.
- R8: The interrupt flag is set by a rising capture while `rise_ie_i` is 1, or by a falling capture while `fall_ie_i` is 1. It is cleared by a write with `flag_wdata_i[2]`=1, a set in the same cycle wins, and `irq_o` equals the flag.
- R9: A new edge overwrites its capture register even while that edge's flag is still set. The capture registers change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external input |
| cnt_i | input | CNT_W | Running counter value to timestamp with |
| connect_i | input | 1 | 1 connects the pin to the capture logic |
| invert_i | input | 1 | 1 inverts the connected level |
| cap_en_i | input | 1 | 1 enables capturing |
| rise_ie_i | input | 1 | Interrupt enable for rising captures |
| fall_ie_i | input | 1 | Interrupt enable for falling captures |
| flag_wr_i | input | 1 | One-cycle flag write strobe |
| flag_wdata_i | input | 3 | Flag write data: bit0 rise, bit1 fall (clear on 0), bit2 interrupt (clear on 1) |
| rise_cap_o | output | CNT_W | Rising-edge capture register |
| fall_cap_o | output | CNT_W | Falling-edge capture register |
| rise_flag_o | output | 1 | Rising capture flag |
| fall_flag_o | output | 1 | Falling capture flag |
| irq_o | output | 1 | Interrupt, equal to the combined flag |

## Verification
A wrong synchroniser depth or a wrong previous-level register shows up in the capture registers. The latched count is off by one or more cycles, and the fault is visible at the first edge after it occurs. An inverted edge classification, or a stale previous level after an invert or connect change, swaps which register and flag respond. It can also produce a spurious capture within three cycles. A wrong flag priority between set and clear only shows when a write coincides with a capture. The stimulus therefore sweeps the write position across the capture cycle, and every output is compared against the reference on every clock.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned BIT_RISE  = 0;
  localparam int unsigned BIT_FALL  = 1;
  localparam int unsigned BIT_IRQ   = 2;

  // conditioned level seen by edge detection
  function automatic logic condition_level(logic synced, logic connect, logic invert);
    return (synced & connect) ^ invert;
  endfunction

  // sticky flag: set has priority over clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic connect_i,
  input  logic invert_i,
  output logic rise_o,
  output logic fall_o
);
  logic cond_lvl;
  logic prev_q;

  assign cond_lvl = condition_level(level_i, connect_i, invert_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond_lvl;
  end

  assign rise_o = cond_lvl & ~prev_q;
  assign fall_o = ~cond_lvl & prev_q;

  // R2
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  // R3
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cap_latch_regs.sv
module cap_latch_regs
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rise_evt_i,
  input  logic              fall_evt_i,
  input  logic              cap_en_i,
  input  logic              rise_ie_i,
  input  logic              fall_ie_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  output logic [CNT_W-1:0]  rise_cap_o,
  output logic [CNT_W-1:0]  fall_cap_o,
  output logic              rise_flag_o,
  output logic              fall_flag_o,
  output logic              irq_flag_o
);
  logic rise_take, fall_take, irq_set;
  logic rise_clr, fall_clr, irq_clr;

  assign rise_take = cap_en_i & rise_evt_i;
  assign fall_take = cap_en_i & fall_evt_i;
  assign irq_set   = (rise_take & rise_ie_i) | (fall_take & fall_ie_i);
  assign rise_clr  = flag_wr_i & ~flag_wdata_i[BIT_RISE];
  assign fall_clr  = flag_wr_i & ~flag_wdata_i[BIT_FALL];
  assign irq_clr   = flag_wr_i &  flag_wdata_i[BIT_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cap_o  <= '0;
      fall_cap_o  <= '0;
      rise_flag_o <= 1'b0;
      fall_flag_o <= 1'b0;
      irq_flag_o  <= 1'b0;
    end else begin
      if (rise_take) rise_cap_o <= cnt_i;
      if (fall_take) fall_cap_o <= cnt_i;
      rise_flag_o <= flag_next(rise_flag_o, rise_take, rise_clr);
      fall_flag_o <= flag_next(fall_flag_o, fall_take, fall_clr);
      irq_flag_o  <= flag_next(irq_flag_o, irq_set, irq_clr);
    end
  end

  // R2
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && rise_evt_i) |=> (rise_cap_o == $past(cnt_i)));
  // R6
  cap_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> ($stable(rise_cap_o) && $stable(fall_cap_o)));
  // R7
  rise_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_flag_o) |-> $past(rise_evt_i && cap_en_i));
  // R7
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && !flag_wdata_i[BIT_RISE] && !(cap_en_i && rise_evt_i)) |=> !rise_flag_o);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) |-> $past(cap_en_i && ((rise_evt_i && rise_ie_i) || (fall_evt_i && fall_ie_i))));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              connect_i,
  input  logic              invert_i,
  input  logic              cap_en_i,
  input  logic              rise_ie_i,
  input  logic              fall_ie_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  output logic [CNT_W-1:0]  rise_cap_o,
  output logic [CNT_W-1:0]  fall_cap_o,
  output logic              rise_flag_o,
  output logic              fall_flag_o,
  output logic              irq_o
);
  logic pin_sync;
  logic rise_evt, fall_evt;
  logic irq_flag;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cap_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pin_sync),
    .connect_i(connect_i), .invert_i(invert_i),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  cap_latch_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .rise_evt_i(rise_evt), .fall_evt_i(fall_evt),
    .cap_en_i(cap_en_i), .rise_ie_i(rise_ie_i), .fall_ie_i(fall_ie_i),
    .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .rise_cap_o(rise_cap_o), .fall_cap_o(fall_cap_o),
    .rise_flag_o(rise_flag_o), .fall_flag_o(fall_flag_o),
    .irq_flag_o(irq_flag)
  );

  assign irq_o = irq_flag;

  // R4
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));
  // R5
  disc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!connect_i && $past(!connect_i) && $stable(invert_i)) |-> !(rise_evt || fall_evt));
endmodule

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic [15:0] cnt_i = 16'hFFFF;
  logic        connect_i = 1'b0, invert_i = 1'b0, cap_en_i = 1'b0;
  logic        rise_ie_i = 1'b0, fall_ie_i = 1'b0;
  logic        flag_wr_i = 1'b0;
  logic [2:0]  flag_wdata_i = 3'b000;
  logic [15:0] rise_cap_o, fall_cap_o;
  logic        rise_flag_o, fall_flag_o, irq_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  edge_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cnt_i(cnt_i),
    .connect_i(connect_i), .invert_i(invert_i), .cap_en_i(cap_en_i),
    .rise_ie_i(rise_ie_i), .fall_ie_i(fall_ie_i),
    .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .rise_cap_o(rise_cap_o), .fall_cap_o(fall_cap_o),
    .rise_flag_o(rise_flag_o), .fall_flag_o(fall_flag_o), .irq_o(irq_o)
  );

  // reference model: pin samples delayed in a queue, conditioned level compared with last
  int pinq[$];
  int m_prev, m_rc, m_fc, m_rf, m_ff, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinq.delete(); pinq.push_back(0); pinq.push_back(0);
      m_prev = 0; m_rc = 0; m_fc = 0; m_rf = 0; m_ff = 0; m_irq = 0;
    end else begin
      int old, lvl, up, dn, set_i;
      old = pinq[0];
      void'(pinq.pop_front());
      pinq.push_back(pin_i ? 1 : 0);
      lvl = ((old != 0 && connect_i) != invert_i) ? 1 : 0;
      up = (lvl == 1 && m_prev == 0 && cap_en_i) ? 1 : 0;
      dn = (lvl == 0 && m_prev == 1 && cap_en_i) ? 1 : 0;
      m_prev = lvl;
      if (up != 0) m_rc = int'(cnt_i);
      if (dn != 0) m_fc = int'(cnt_i);
      set_i = ((up != 0 && rise_ie_i) || (dn != 0 && fall_ie_i)) ? 1 : 0;
      if (up != 0) m_rf = 1; else if (flag_wr_i && !flag_wdata_i[0]) m_rf = 0;
      if (dn != 0) m_ff = 1; else if (flag_wr_i && !flag_wdata_i[1]) m_ff = 0;
      if (set_i != 0) m_irq = 1; else if (flag_wr_i && flag_wdata_i[2]) m_irq = 0;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s (%s) got %0h expected %0h", tag, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rise_cap", int'(rise_cap_o), m_rc);
      chk("R3 fall_cap", int'(fall_cap_o), m_fc);
      chk("R7 rise_flag", int'(rise_flag_o), m_rf);
      chk("R7 fall_flag", int'(fall_flag_o), m_ff);
      chk("R8 irq", int'(irq_o), m_irq);
    end
    cnt_i = cnt_i - 16'd3;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_flags(input logic [2:0] d);
    @(negedge clk);
    flag_wr_i = 1'b1; flag_wdata_i = d;
    @(negedge clk);
    flag_wr_i = 1'b0; flag_wdata_i = 3'b000;
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_i = 1'b1; wait_cyc(hi);
    pin_i = 1'b0; wait_cyc(lo);
  endtask

  initial begin
    logic [15:0] held_r, held_f, first_r;
    logic [15:0] lfsr;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk("R1 reset rise_cap", int'(rise_cap_o), 0);
    chk("R1 reset fall_cap", int'(fall_cap_o), 0);
    chk("R1 reset flags", int'({rise_flag_o, fall_flag_o, irq_o}), 0);

    phase = "R2 R3";
    connect_i = 1; cap_en_i = 1; rise_ie_i = 1; fall_ie_i = 1;
    wait_cyc(2);
    pulse(10, 10);
    chk("R2 rise flag set", int'(rise_flag_o), 1);
    chk("R3 fall flag set", int'(fall_flag_o), 1);
    chk("R8 irq set", int'(irq_o), 1);

    phase = "R7 R8";
    write_flags(3'b011);
    chk("R7 ones keep flags", int'({rise_flag_o, fall_flag_o}), 3);
    chk("R8 zero keeps irq", int'(irq_o), 1);
    write_flags(3'b100);
    chk("R7 zeros clear flags", int'({rise_flag_o, fall_flag_o}), 0);
    chk("R8 one clears irq", int'(irq_o), 0);

    phase = "R9";
    pulse(4, 6);
    first_r = rise_cap_o;
    pulse(5, 6);
    chk("R9 overwrite while flag set", int'(rise_cap_o != first_r), 1);
    write_flags(3'b100);

    phase = "R4";
    invert_i = 1; wait_cyc(6);
    write_flags(3'b100);
    pulse(7, 7);
    chk("R4 inverted pin rise is falling", int'(fall_flag_o), 1);
    invert_i = 0; wait_cyc(6);
    write_flags(3'b100);

    phase = "R8";
    rise_ie_i = 0; fall_ie_i = 1;
    pulse(5, 1);
    chk("R8 rising not enabled", int'(irq_o), 0);
    wait_cyc(5);
    chk("R8 falling enabled", int'(irq_o), 1);
    write_flags(3'b100);
    rise_ie_i = 1;

    phase = "R5";
    connect_i = 0; wait_cyc(6);
    write_flags(3'b100);
    held_r = rise_cap_o; held_f = fall_cap_o;
    for (int k = 0; k < 5; k++) pulse(3 + k, 4);
    chk("R5 disconnected rise_cap", int'(rise_cap_o), int'(held_r));
    chk("R5 disconnected fall_cap", int'(fall_cap_o), int'(held_f));
    chk("R5 disconnected flags", int'({rise_flag_o, fall_flag_o, irq_o}), 0);
    connect_i = 1; wait_cyc(6);

    phase = "R6";
    cap_en_i = 0;
    held_r = rise_cap_o; held_f = fall_cap_o;
    for (int k = 0; k < 5; k++) pulse(4, 3 + k);
    chk("R6 disabled rise_cap", int'(rise_cap_o), int'(held_r));
    chk("R6 disabled fall_cap", int'(fall_cap_o), int'(held_f));
    chk("R6 disabled flags", int'({rise_flag_o, fall_flag_o, irq_o}), 0);
    cap_en_i = 1;

    phase = "R7 R8 set-vs-clear";
    for (int d = 0; d < 6; d++) begin
      pin_i = 1'b1;
      wait_cyc(d);
      flag_wr_i = 1'b1; flag_wdata_i = 3'b100;
      @(negedge clk);
      flag_wr_i = 1'b0; flag_wdata_i = 3'b000;
      wait_cyc(6);
      pin_i = 1'b0; wait_cyc(8);
    end

    phase = "R2 R3 R4 R7 R8 mixed";
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) pin_i = ~pin_i;
      else if (lfsr[2:0] == 3'd5) pin_i = ~pin_i;
      if (lfsr[9:4] == 6'd7) invert_i = ~invert_i;
      if (lfsr[11:6] == 6'd9) connect_i = ~connect_i;
      if (lfsr[12:7] == 6'd3) cap_en_i = ~cap_en_i;
      rise_ie_i = lfsr[13]; fall_ie_i = lfsr[14];
      flag_wr_i = (lfsr[8:5] == 4'd2);
      flag_wdata_i = lfsr[15:13];
      @(negedge clk);
    end
    flag_wr_i = 1'b0;
    wait_cyc(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule